// File: doc/BRIEF.md
# Write-Completion Acknowledge Poller

After a host has written to a serial EEPROM and closed that write with a stop condition, the memory runs an internally timed programming cycle. While that cycle runs, the memory does not acknowledge its own address. This block uses that behaviour to find out when the cycle has finished. It does not wait for a fixed worst-case delay. It sends a start condition and the write control byte (device address with the read/write bit cleared), then reads the acknowledge bit. A missing acknowledge means the memory is still busy: the block sends a stop and tries again. An acknowledge means the cycle is over.

The host starts a poll with a request, which carries the 7-bit device address, a maximum attempt count and a flag that chooses what happens after a successful poll. With the flag clear, the block closes the bus with a stop. With the flag set, it leaves the transaction open so that the next read or write command can follow at once. The block drives a bit-level bus engine one operation at a time (start, send byte, stop), and that engine returns a completion strobe and the sampled acknowledge bit. When the poll ends, the block pulses done and reports how many attempts it made and whether the attempt limit ran out.

Top module: `ack_poll_master`

## Requirements
- R1: After reset, busy_o, done_o, timeout_o and cmd_valid_o are low and attempts_o is zero.
- R2: A request accepted while idle begins an attempt. Each attempt issues op START (code 0), then op BYTE (code 1) with cmd_byte_o = {dev_addr, 1'b0}, so the address sits in bits 7:1 and bit 0, the write flag, is 0.
- R3: If the engine reports eng_ack_i = 0 for the control byte and the limit has not been reached, the next operation is STOP (code 2), followed by a new attempt that begins with START.
- R4: If the engine reports eng_ack_i = 1 for the control byte and the keep-open flag is 0, one STOP is issued, then the block finishes with timeout_o = 0.
- R5: If the engine reports eng_ack_i = 1 and the keep-open flag is 1, the block finishes with timeout_o = 0 and issues no STOP or any other operation.
- R6: If the control byte of the attempt whose number equals the limit is not acknowledged, the block issues STOP and finishes with timeout_o = 1. A limit of zero counts as one.
- R7: At finish, attempts_o equals the number of START operations issued in that poll. attempts_o and timeout_o hold their values until the next accepted request.
- R8: done_o is high for exactly one clock cycle, and it is high in the cycle that follows the cycle in which the final eng_done_i was high.
- R9: A request that arrives while busy_o is high is ignored. The running poll keeps its address, its limit and its keep-open choice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Start a poll (taken only when idle) |
| dev_addr_i | input | 7 | Device address for the control byte |
| max_polls_i | input | CNT_W | Attempt limit (0 treated as 1) |
| keep_open_i | input | 1 | 1: leave the bus open after an acknowledge; 0: send stop |
| busy_o | output | 1 | A poll is in progress |
| done_o | output | 1 | One-cycle finish pulse |
| timeout_o | output | 1 | The last poll ran out of attempts |
| attempts_o | output | CNT_W | Attempts used by the last poll |
| cmd_valid_o | output | 1 | An operation is requested from the engine |
| cmd_op_o | output | 2 | Operation: 0 start, 1 send byte, 2 stop |
| cmd_byte_o | output | 8 | Byte to send for op 1 |
| eng_done_i | input | 1 | Engine finished the current operation (one-cycle strobe) |
| eng_ack_i | input | 1 | Acknowledge sampled for a byte (1 = acknowledged), valid with eng_done_i |

## Verification
The assertions assume that the engine raises eng_done_i for a single cycle, only while cmd_valid_o is high, and no sooner than the cycle after it sees a new operation. They also assume that eng_ack_i is meaningful only together with a byte completion. The bench engine model takes a new operation on a falling edge, counts a fixed latency and then raises the strobe for one full cycle. It ignores cmd_valid_o while its strobe is high, so each operation is counted only once. Scripted acknowledge patterns produce busy runs of various lengths, and a conflicting request is injected in the middle of a poll.

// File: rtl/apm_pkg.sv
package apm_pkg;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_BYTE  = 2'd1,
    OP_STOP  = 2'd2
  } bus_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_CTRL,
    ST_STOP_RETRY,
    ST_STOP_OK,
    ST_STOP_TO,
    ST_FIN
  } seq_st_e;

  // Control byte for a write-direction address phase: address on top, R/W = 0.
  function automatic logic [7:0] ctrl_write_byte(input logic [6:0] addr);
    return {addr, 1'b0};
  endfunction

endpackage

// File: rtl/apm_attempt_ctr.sv
module apm_attempt_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic [CNT_W-1:0] count_o,
  output logic             at_limit_o
);

  // A limit of zero still allows one attempt.
  function automatic logic [CNT_W-1:0] eff_limit(input logic [CNT_W-1:0] lim);
    return (lim == '0) ? CNT_W'(1) : lim;
  endfunction

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + CNT_W'(1);
  end

  assign count_o    = cnt_q;
  assign at_limit_o = (cnt_q >= eff_limit(limit_i));

  // R6: the attempt count never passes the effective limit
  a_r6_count_within_limit: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |-> cnt_q <= eff_limit(limit_i));

endmodule

// File: rtl/apm_seq_fsm.sv
module apm_seq_fsm
  import apm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       keep_open_i,
  input  logic       at_limit_i,
  input  logic       eng_done_i,
  input  logic       eng_ack_i,
  output seq_st_e    state_o,
  output logic       cmd_valid_o,
  output logic [1:0] cmd_op_o,
  output logic       ev_attempt_o,
  output logic       ev_finish_o,
  output logic       ev_timeout_o
);

  seq_st_e st_q, st_d;

  logic ev_ack, ev_nack;
  assign ev_ack  = (st_q == ST_CTRL) && eng_done_i && eng_ack_i;
  assign ev_nack = (st_q == ST_CTRL) && eng_done_i && !eng_ack_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:       if (start_i) st_d = ST_START;
      ST_START:      if (eng_done_i) st_d = ST_CTRL;
      ST_CTRL: begin
        if (ev_ack)       st_d = keep_open_i ? ST_FIN : ST_STOP_OK;
        else if (ev_nack) st_d = at_limit_i ? ST_STOP_TO : ST_STOP_RETRY;
      end
      ST_STOP_RETRY: if (eng_done_i) st_d = ST_START;
      ST_STOP_OK,
      ST_STOP_TO:    if (eng_done_i) st_d = ST_FIN;
      ST_FIN:        st_d = ST_IDLE;
      default:       st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_comb begin
    cmd_valid_o = 1'b1;
    cmd_op_o    = OP_STOP;
    unique case (st_q)
      ST_START:      cmd_op_o = OP_START;
      ST_CTRL:       cmd_op_o = OP_BYTE;
      ST_STOP_RETRY,
      ST_STOP_OK,
      ST_STOP_TO:    cmd_op_o = OP_STOP;
      default:       cmd_valid_o = 1'b0;
    endcase
  end

  assign state_o      = st_q;
  assign ev_attempt_o = (st_q == ST_START) && eng_done_i;
  assign ev_finish_o  = (st_d == ST_FIN) && (st_q != ST_FIN);
  assign ev_timeout_o = (st_q == ST_STOP_TO);

  // R3: a busy answer below the limit is followed by a stop request
  a_r3_nack_then_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_nack && !at_limit_i) |=> (cmd_valid_o && cmd_op_o == OP_STOP));

  // R5: acknowledge with keep-open goes straight to finish, no stop
  a_r5_keep_skips_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ack && keep_open_i) |=> (st_q == ST_FIN && !cmd_valid_o));

  // R2: a new attempt always opens with a start request
  a_r2_retry_opens_start: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_STOP_RETRY && eng_done_i) |=> (cmd_op_o == OP_START));

endmodule

// File: rtl/ack_poll_master.sv
module ack_poll_master
  import apm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic [6:0]       dev_addr_i,
  input  logic [CNT_W-1:0] max_polls_i,
  input  logic             keep_open_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             timeout_o,
  output logic [CNT_W-1:0] attempts_o,
  output logic             cmd_valid_o,
  output logic [1:0]       cmd_op_o,
  output logic [7:0]       cmd_byte_o,
  input  logic             eng_done_i,
  input  logic             eng_ack_i
);

  seq_st_e          state;
  logic             accept;
  logic [6:0]       addr_q;
  logic [CNT_W-1:0] lim_q;
  logic             keep_q;
  logic [CNT_W-1:0] count;
  logic             at_limit;
  logic             ev_attempt, ev_finish, ev_timeout;
  logic             to_q;
  logic [CNT_W-1:0] att_q;

  assign busy_o = (state != ST_IDLE);
  assign accept = req_i && !busy_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      lim_q  <= '0;
      keep_q <= 1'b0;
    end else if (accept) begin
      addr_q <= dev_addr_i;
      lim_q  <= max_polls_i;
      keep_q <= keep_open_i;
    end
  end

  apm_attempt_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (accept),
    .inc_i      (ev_attempt),
    .limit_i    (lim_q),
    .count_o    (count),
    .at_limit_o (at_limit)
  );

  apm_seq_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (accept),
    .keep_open_i  (keep_q),
    .at_limit_i   (at_limit),
    .eng_done_i   (eng_done_i),
    .eng_ack_i    (eng_ack_i),
    .state_o      (state),
    .cmd_valid_o  (cmd_valid_o),
    .cmd_op_o     (cmd_op_o),
    .ev_attempt_o (ev_attempt),
    .ev_finish_o  (ev_finish),
    .ev_timeout_o (ev_timeout)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      to_q  <= 1'b0;
      att_q <= '0;
    end else if (accept) begin
      to_q  <= 1'b0;
      att_q <= '0;
    end else if (ev_finish) begin
      to_q  <= ev_timeout;
      att_q <= count;
    end
  end

  assign cmd_byte_o = ctrl_write_byte(addr_q);
  assign done_o     = (state == ST_FIN);
  assign timeout_o  = to_q;
  assign attempts_o = att_q;

  // R8: finish pulse lasts one cycle
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R6: a timeout result reports exactly the effective limit of attempts
  a_r6_timeout_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && timeout_o) |-> (attempts_o == ((lim_q == '0) ? CNT_W'(1) : lim_q)));

  // R9: poll parameters stay frozen while busy
  a_r9_req_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> ($stable(addr_q) && $stable(lim_q) && $stable(keep_q)));

  // R7: results hold between finish and the next accepted request
  a_r7_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !accept) |=> ($stable(attempts_o) && $stable(timeout_o)));

endmodule

// File: tb/sim_ack_poll_master.sv
module sim_ack_poll_master;

  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0;
  logic [6:0]    addr = '0;
  logic [CW-1:0] maxp = '0;
  logic          keep = 1'b0;
  logic          busy, done, tmo, cvalid;
  logic [CW-1:0] att;
  logic [1:0]    cop;
  logic [7:0]    cbyte;
  logic          edone = 1'b0;
  logic          eack = 1'b0;

  always #5 clk = ~clk;

  ack_poll_master #(.CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req), .dev_addr_i(addr),
    .max_polls_i(maxp), .keep_open_i(keep), .busy_o(busy), .done_o(done),
    .timeout_o(tmo), .attempts_o(att), .cmd_valid_o(cvalid), .cmd_op_o(cop),
    .cmd_byte_o(cbyte), .eng_done_i(edone), .eng_ack_i(eack)
  );

  int errors = 0;
  int checks = 0;

  task automatic check(input bit ok, input string req_tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req_tag, act, exp);
    end
  endtask

  // engine model and monitors, all on the falling edge
  int       cyc = 0;
  int       ecnt = 0;
  logic [1:0] cur_op = 2'd0;
  int       nbytes = 0;
  int       nacks = 0;
  int       nlog = 0;
  logic [1:0] log_op [64];
  logic [7:0] log_byte [64];
  int       done_first = -1;
  int       done_width = 0;
  int       last_clear = -1;
  bit       done_prev = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (done) begin
      if (!done_prev) done_first = cyc;
      done_width++;
    end
    done_prev = done;
    if (edone) begin
      edone = 1'b0;
      eack  = 1'b0;
      last_clear = cyc;
    end else if (ecnt > 0) begin
      ecnt--;
      if (ecnt == 0) begin
        edone = 1'b1;
        if (cur_op == 2'd1) begin
          eack = (nbytes >= nacks);
          nbytes++;
        end
      end
    end else if (cvalid && rst_n) begin
      if (nlog < 64) begin
        log_op[nlog]   = cop;
        log_byte[nlog] = cbyte;
      end
      nlog++;
      cur_op = cop;
      ecnt   = 2;
    end
  end

  task automatic reset_check();
    #1;
    check(!busy && !done && !tmo && !cvalid, "R1 idle outputs", {busy, done, tmo, cvalid}, 0);
    check(att == 0, "R1 attempts", int'(att), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
  endtask

  // one poll; intr != 0 injects a conflicting request mid-run
  task automatic run_poll(input logic [6:0] a, input int mx, input bit kp, input int nk,
                          input bit intr, input string tag);
    int eff, att_exp, k, wd;
    bit succ;
    logic [1:0] eop [64];
    nlog = 0; nbytes = 0; nacks = nk; done_width = 0; done_first = -1;
    @(negedge clk);
    addr = a; maxp = CW'(mx); keep = kp; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    addr = ~a; maxp = CW'(1); keep = ~kp;
    wd = 0;
    while (done_width == 0 && wd < 2000) begin
      @(negedge clk);
      wd++;
      if (intr && wd == 5) req = 1'b1;
      if (intr && wd == 6) req = 1'b0;
    end
    check(wd < 2000, {tag, " R8 watchdog"}, wd, 0);
    check(done_first == last_clear, {tag, " R8 done timing"}, done_first, last_clear);
    eff = (mx == 0) ? 1 : mx;
    succ = (nk < eff);
    att_exp = succ ? nk + 1 : eff;
    k = 0;
    for (int i = 0; i < att_exp; i++) begin
      eop[k++] = 2'd0;
      eop[k++] = 2'd1;
      if (i < att_exp - 1 || !succ) eop[k++] = 2'd2;
    end
    if (succ && !kp) eop[k++] = 2'd2;
    check(tmo == !succ, {tag, succ ? " R4 timeout flag" : " R6 timeout flag"}, tmo, !succ);
    check(int'(att) == att_exp, {tag, " R7 attempts"}, int'(att), att_exp);
    repeat (6) @(negedge clk);
    check(done_width == 1, {tag, " R8 done width"}, done_width, 1);
    check(nlog == k, {tag, kp ? " R5 op count" : " R3 op count"}, nlog, k);
    for (int i = 0; i < k && i < nlog; i++) begin
      if (log_op[i] != eop[i])
        check(0, {tag, " R3 op order"}, log_op[i], eop[i]);
      if (log_op[i] == 2'd1 && log_byte[i] != {a, 1'b0})
        check(0, {tag, intr ? " R9 ctrl byte" : " R2 ctrl byte"}, log_byte[i], {a, 1'b0});
    end
    check(int'(att) == att_exp && tmo == !succ, {tag, " R7 hold"}, int'(att), att_exp);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    reset_check();
    run_poll(7'h50, 8, 0, 0, 0, "immediate ack R4");
    run_poll(7'h2A, 8, 0, 3, 0, "three busy R3");
    run_poll(7'h11, 8, 1, 2, 0, "keep open R5");
    run_poll(7'h7F, 3, 0, 3, 0, "limit hit R6");
    run_poll(7'h01, 4, 0, 3, 0, "limit just enough R6");
    run_poll(7'h33, 0, 0, 5, 0, "zero limit R6");
    run_poll(7'h45, 10, 0, 4, 1, "req while busy R9");
    run_poll(7'h22, 5, 1, 0, 0, "keep first try R5");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule